// File: doc/BRIEF.md
# Grid Reconnection Permit Controller

This block decides when an islanded microgrid may close its tie breaker back onto the utility grid. It takes paired measurements of voltage magnitude, frequency and phase from both sides of the point of coupling. It counts how many consecutive paired samples fall inside a combined acceptance window. Once enough samples in a row have passed, it issues a single breaker-close pulse. On that same edge it moves the inverter controller from voltage-frequency regulation to active-reactive power regulation.

Supervisory logic asserts the request level to start an alignment attempt. While the attempt runs, the inverter steers its phase toward the grid. If the request is removed, or an island command arrives, the block drops back to the islanded state and selects voltage-frequency control. Producing the measurements and timing the breaker mechanics are left to other blocks.

Top module: `resync_permit`

## Requirements
- R1: After a synchronous reset, `close_o` is 0 and `pq_mode_o` is 0 (voltage-frequency control), and the block is islanded.
- R2: Paired samples have no effect until `req_i` has been high for one clock edge. Samples seen while islanded are neither counted nor able to produce a close.
- R3: A sample counts only in a cycle where `mg_valid_i` and `gr_valid_i` are both 1. In every other cycle the run of good samples neither advances nor restarts.
- R4: A sample fails the voltage check unless |mg_mag - gr_mag| * 20 < gr_mag, meaning the mismatch is below 5 % of the grid magnitude. Magnitudes are unsigned volts.
- R5: A sample fails the frequency check unless |mg_freq - gr_freq| < 300. Frequencies are unsigned millihertz.
- R6: A sample fails the phase check unless the 16-bit wrapped signed difference mg_phase - gr_phase has magnitude below 1820, which is about 10 degrees. A full turn is 65536 counts, and the check holds across the wrap point.
- R7: A sample fails unless the microgrid magnitude lies in 582..610 V and the microgrid frequency lies in 59700..60300 mHz, both bounds inclusive.
- R8: `close_o` pulses high for exactly one cycle after the edge that takes the HOLD-th consecutive passing sample. Any failing sample restarts the count from zero.
- R9: `pq_mode_o` becomes 1 on the same edge as the close pulse. It stays 1 while connected, and later samples, good or bad, produce no further close.
- R10: If `req_i` is 0 or `island_i` is 1 at an edge, the next state is islanded, with `pq_mode_o` = 0, no close and the count cleared. This takes priority over a close on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Reconnection request level |
| island_i | input | 1 | Island command |
| mg_valid_i | input | 1 | Microgrid sample strobe |
| mg_mag_i | input | 12 | Microgrid voltage magnitude, volts |
| mg_freq_i | input | 17 | Microgrid frequency, mHz |
| mg_phase_i | input | 16 | Microgrid phase, 65536 per turn |
| gr_valid_i | input | 1 | Grid sample strobe |
| gr_mag_i | input | 12 | Grid voltage magnitude, volts |
| gr_freq_i | input | 17 | Grid frequency, mHz |
| gr_phase_i | input | 16 | Grid phase, 65536 per turn |
| close_o | output | 1 | One-cycle breaker-close pulse |
| pq_mode_o | output | 1 | 1 = active-reactive power control, 0 = voltage-frequency control |

## Verification
The bench builds the block with HOLD_SAMPLES set to 16 and keeps every window limit at its default. A shorter run lets each test reach the exact sample that should close, or fall one short of it. This makes it cheap to place a violation, a strobe gap or an abort on any chosen sample of the run. The default limits keep the one-count boundaries reachable: 28 V against 30 V, 299 mHz against 300 mHz, 1819 counts against 1820 counts across the phase wrap, and the inclusive band edges.

// File: rtl/resync_pkg.sv
`timescale 1ns/1ps
package resync_pkg;
  typedef enum logic [1:0] {
    ST_ISLANDED  = 2'd0,
    ST_ALIGNING  = 2'd1,
    ST_ARMED     = 2'd2,
    ST_CONNECTED = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rs_absdiff.sv
`timescale 1ns/1ps
// Unsigned absolute difference of two words.
module rs_absdiff #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] d_o
);
  always_comb begin
    if (a_i > b_i) d_o = a_i - b_i;
    else           d_o = b_i - a_i;
  end
endmodule

// File: rtl/rs_window_chk.sv
`timescale 1ns/1ps
// Combined magnitude / frequency / phase / band acceptance window.
module rs_window_chk #(
  parameter int MAG_W    = 12,
  parameter int FREQ_W   = 17,
  parameter int PH_W     = 16,
  parameter int VOLT_DIV = 20,
  parameter int FREQ_TOL = 300,
  parameter int PH_TOL   = 1820,
  parameter int MAG_MIN  = 582,
  parameter int MAG_MAX  = 610,
  parameter int FREQ_MIN = 59700,
  parameter int FREQ_MAX = 60300
) (
  input  logic [MAG_W-1:0]  mg_mag_i,
  input  logic [FREQ_W-1:0] mg_freq_i,
  input  logic [PH_W-1:0]   mg_phase_i,
  input  logic [MAG_W-1:0]  gr_mag_i,
  input  logic [FREQ_W-1:0] gr_freq_i,
  input  logic [PH_W-1:0]   gr_phase_i,
  output logic              ok_o
);
  localparam int PROD_W = MAG_W + $clog2(VOLT_DIV + 1);

  logic [MAG_W-1:0]  mag_diff;
  logic [FREQ_W-1:0] freq_diff;
  logic [PROD_W-1:0] mag_scaled;
  logic [PH_W-1:0]   ph_raw;
  logic [PH_W:0]     ph_mag;
  logic volt_ok, freq_ok, ph_ok, band_ok;

  rs_absdiff #(.W(MAG_W))  u_mag_diff  (.a_i(mg_mag_i),  .b_i(gr_mag_i),  .d_o(mag_diff));
  rs_absdiff #(.W(FREQ_W)) u_freq_diff (.a_i(mg_freq_i), .b_i(gr_freq_i), .d_o(freq_diff));

  always_comb begin
    mag_scaled = PROD_W'(mag_diff) * PROD_W'(VOLT_DIV);
    volt_ok    = mag_scaled < PROD_W'(gr_mag_i);
    freq_ok    = freq_diff < FREQ_W'(FREQ_TOL);
    // wrapped signed phase error, magnitude taken one bit wider
    ph_raw = mg_phase_i - gr_phase_i;
    if (ph_raw[PH_W-1]) ph_mag = (PH_W+1)'(0) - {1'b1, ph_raw};
    else                ph_mag = {1'b0, ph_raw};
    ph_ok   = ph_mag < (PH_W+1)'(PH_TOL);
    band_ok = (mg_mag_i  >= MAG_W'(MAG_MIN))   && (mg_mag_i  <= MAG_W'(MAG_MAX)) &&
              (mg_freq_i >= FREQ_W'(FREQ_MIN)) && (mg_freq_i <= FREQ_W'(FREQ_MAX));
    ok_o = volt_ok && freq_ok && ph_ok && band_ok;
  end
endmodule

// File: rtl/rs_hold_cnt.sv
`timescale 1ns/1ps
// Consecutive-pass counter; last_o marks the final sample of the run.
module rs_hold_cnt #(
  parameter int HOLD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (inc_i)   cnt <= cnt + 1'b1;
  end

  assign last_o = (cnt == CW'(HOLD - 1));

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(HOLD));
  a_r8_no_inc_past_last: assert property (@(posedge clk) disable iff (rst)
    (last_o && !clr_i) |-> !inc_i);
endmodule

// File: rtl/resync_permit.sv
`timescale 1ns/1ps
module resync_permit #(
  parameter int MAG_W        = 12,
  parameter int FREQ_W       = 17,
  parameter int PH_W         = 16,
  parameter int HOLD_SAMPLES = 64,
  parameter int VOLT_DIV     = 20,
  parameter int FREQ_TOL     = 300,
  parameter int PH_TOL       = 1820,
  parameter int MAG_MIN      = 582,
  parameter int MAG_MAX      = 610,
  parameter int FREQ_MIN     = 59700,
  parameter int FREQ_MAX     = 60300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              island_i,
  input  logic              mg_valid_i,
  input  logic [MAG_W-1:0]  mg_mag_i,
  input  logic [FREQ_W-1:0] mg_freq_i,
  input  logic [PH_W-1:0]   mg_phase_i,
  input  logic              gr_valid_i,
  input  logic [MAG_W-1:0]  gr_mag_i,
  input  logic [FREQ_W-1:0] gr_freq_i,
  input  logic [PH_W-1:0]   gr_phase_i,
  output logic              close_o,
  output logic              pq_mode_o
);
  import resync_pkg::*;

  rs_state_e state;
  logic win_ok, sample, abort, seeking, cnt_last, cnt_clr, cnt_inc;

  rs_window_chk #(
    .MAG_W(MAG_W), .FREQ_W(FREQ_W), .PH_W(PH_W), .VOLT_DIV(VOLT_DIV),
    .FREQ_TOL(FREQ_TOL), .PH_TOL(PH_TOL), .MAG_MIN(MAG_MIN), .MAG_MAX(MAG_MAX),
    .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX)
  ) u_window (
    .mg_mag_i(mg_mag_i), .mg_freq_i(mg_freq_i), .mg_phase_i(mg_phase_i),
    .gr_mag_i(gr_mag_i), .gr_freq_i(gr_freq_i), .gr_phase_i(gr_phase_i),
    .ok_o(win_ok)
  );

  rs_hold_cnt #(.HOLD(HOLD_SAMPLES)) u_hold (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(cnt_inc), .last_o(cnt_last)
  );

  always_comb begin
    sample  = mg_valid_i && gr_valid_i;
    abort   = !req_i || island_i;
    seeking = (state == ST_ALIGNING) || (state == ST_ARMED);
    cnt_clr = abort || !seeking || (sample && (!win_ok || cnt_last));
    cnt_inc = !cnt_clr && sample && win_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ISLANDED;
      close_o   <= 1'b0;
      pq_mode_o <= 1'b0;
    end else begin
      close_o <= 1'b0;
      if (abort) begin
        state     <= ST_ISLANDED;
        pq_mode_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ISLANDED: state <= ST_ALIGNING;
          ST_ALIGNING, ST_ARMED: begin
            if (sample) begin
              if (!win_ok) begin
                state <= ST_ALIGNING;
              end else if (cnt_last) begin
                state     <= ST_CONNECTED;
                close_o   <= 1'b1;
                pq_mode_o <= 1'b1;
              end else begin
                state <= ST_ARMED;
              end
            end
          end
          ST_CONNECTED: pq_mode_o <= 1'b1;
          default: state <= ST_ISLANDED;
        endcase
      end
    end
  end

  a_r8_close_single: assert property (@(posedge clk) disable iff (rst)
    close_o |=> !close_o);
  a_r8_close_needs_window: assert property (@(posedge clk) disable iff (rst)
    close_o |-> $past(sample && win_ok));
  a_r9_close_sets_pq: assert property (@(posedge clk) disable iff (rst)
    close_o |-> pq_mode_o);
  a_r9_pq_rises_on_close: assert property (@(posedge clk) disable iff (rst)
    $rose(pq_mode_o) |-> close_o);
  a_r10_abort_islands: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!pq_mode_o && !close_o && state == ST_ISLANDED));
  a_r2_no_close_from_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ISLANDED) |=> !close_o);
endmodule

// File: tb/resync_permit_tb_top.sv
`timescale 1ns/1ps
module resync_permit_tb_top;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, isl = 1'b0, mv = 1'b0, gv = 1'b0;
  logic [11:0] mm = 12'd600, gm = 12'd600;
  logic [16:0] mf = 17'd60000, gf = 17'd60000;
  logic [15:0] mp = 16'd1000, gp = 16'd1000;
  logic close_w, pq_w;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  resync_permit #(.HOLD_SAMPLES(HOLD)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .island_i(isl),
    .mg_valid_i(mv), .mg_mag_i(mm), .mg_freq_i(mf), .mg_phase_i(mp),
    .gr_valid_i(gv), .gr_mag_i(gm), .gr_freq_i(gf), .gr_phase_i(gp),
    .close_o(close_w), .pq_mode_o(pq_w)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; outputs read 1 ns after the edge, inputs then changed
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put(input int a_m, input int b_m, input int a_f, input int b_f,
                     input int a_p, input int b_p, input logic v_a, input logic v_b);
    mm = 12'(a_m); gm = 12'(b_m); mf = 17'(a_f); gf = 17'(b_f);
    mp = 16'(a_p); gp = 16'(b_p); mv = v_a; gv = v_b;
  endtask

  task automatic good(); put(600, 600, 60000, 60000, 1000, 1000, 1'b1, 1'b1); endtask
  task automatic idle(); mv = 1'b0; gv = 1'b0; endtask

  task automatic restart();
    idle(); isl = 1'b0; req = 1'b0; step();
    req = 1'b1; step();
  endtask

  // HOLD samples of one pattern; expect close on the last one or never
  task automatic window_case(input string tag, input int a_m, input int b_m,
                             input int a_f, input int b_f, input int a_p,
                             input int b_p, input int expect_close);
    int seen = 0;
    restart();
    for (int i = 0; i < HOLD; i++) begin
      put(a_m, b_m, a_f, b_f, a_p, b_p, 1'b1, 1'b1);
      step();
      seen += int'(close_w);
      if (i == HOLD - 1) chk({tag, " close on last sample"}, int'(close_w), expect_close);
    end
    idle();
    chk({tag, " close count"}, seen, expect_close);
    chk({tag, " pq mode"}, int'(pq_w), expect_close);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
    chk("R1 close after reset", int'(close_w), 0);
    chk("R1 pq after reset", int'(pq_w), 0);
  endtask

  task automatic t_idle();
    int seen = 0;
    req = 1'b0;
    for (int i = 0; i < HOLD + 4; i++) begin good(); step(); seen += int'(close_w); end
    idle();
    chk("R2 no close while islanded", seen, 0);
    chk("R2 pq while islanded", int'(pq_w), 0);
  endtask

  task automatic t_nominal();
    int seen = 0;
    window_case("R8 nominal run", 600, 600, 60000, 60000, 1000, 1000, 1);
    for (int i = 0; i < 5; i++) begin
      put(700, 500, 61000, 59000, 0, 30000, 1'b1, 1'b1); step(); seen += int'(close_w);
    end
    idle();
    chk("R9 no further close when connected", seen, 0);
    chk("R9 pq held when connected", int'(pq_w), 1);
  endtask

  task automatic t_restart();
    int seen = 0;
    restart();
    for (int i = 0; i < 10; i++) begin good(); step(); seen += int'(close_w); end
    put(600, 600, 60300, 60000, 1000, 1000, 1'b1, 1'b1); step(); seen += int'(close_w);
    for (int i = 0; i < HOLD - 1; i++) begin good(); step(); seen += int'(close_w); end
    chk("R8 restart: no close one short", seen, 0);
    good(); step();
    chk("R8 restart: close after full run", int'(close_w), 1);
    idle(); step();
    chk("R8 close is one cycle", int'(close_w), 0);
  endtask

  task automatic t_strobe();
    int seen = 0;
    restart();
    for (int i = 0; i < 8; i++) begin good(); step(); seen += int'(close_w); end
    for (int i = 0; i < 5; i++) begin
      put(100, 900, 50000, 70000, 0, 32768, 1'b1, 1'b0); step(); seen += int'(close_w);
    end
    for (int i = 0; i < 3; i++) begin
      put(100, 900, 50000, 70000, 0, 32768, 1'b0, 1'b1); step(); seen += int'(close_w);
    end
    for (int i = 0; i < 7; i++) begin good(); step(); seen += int'(close_w); end
    chk("R3 single strobes neither count nor break", seen, 0);
    good(); step();
    chk("R3 close after 16 paired samples", int'(close_w), 1);
    idle();
  endtask

  task automatic t_abort();
    int seen = 0;
    window_case("R10 setup connect", 600, 600, 60000, 60000, 1000, 1000, 1);
    isl = 1'b1; step(); isl = 1'b0;
    chk("R10 island command clears pq", int'(pq_w), 0);
    restart();
    for (int i = 0; i < 10; i++) begin good(); step(); end
    req = 1'b0; step(); req = 1'b1; step();
    for (int i = 0; i < HOLD - 1; i++) begin good(); step(); seen += int'(close_w); end
    chk("R10 request drop restarts count", seen, 0);
    good(); step();
    chk("R10 close after fresh run", int'(close_w), 1);
    restart();
    for (int i = 0; i < HOLD - 1; i++) begin good(); step(); end
    good(); isl = 1'b1; step(); isl = 1'b0; idle();
    chk("R10 island beats close", int'(close_w), 0);
    chk("R10 island beats pq", int'(pq_w), 0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_nominal();
    t_restart();
    t_strobe();
    window_case("R4 voltage 28 V in", 610, 582, 60000, 60000, 1000, 1000, 1);
    window_case("R4 voltage 30 V out", 610, 580, 60000, 60000, 1000, 1000, 0);
    window_case("R5 freq 299 in", 600, 600, 60299, 60000, 1000, 1000, 1);
    window_case("R5 freq 300 out", 600, 600, 60300, 60000, 1000, 1000, 0);
    window_case("R6 phase +1819 wrap in", 600, 600, 60000, 60000, 16, 63733, 1);
    window_case("R6 phase -1819 in", 600, 600, 60000, 60000, 0, 1819, 1);
    window_case("R6 phase 1820 wrap out", 600, 600, 60000, 60000, 16, 63732, 0);
    window_case("R7 mg freq above band", 600, 600, 60301, 60301, 1000, 1000, 0);
    window_case("R7 mg mag below band", 581, 581, 60000, 60000, 1000, 1000, 0);
    window_case("R7 band low edges in", 582, 582, 59700, 59700, 1000, 1000, 1);
    t_abort();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule